// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in without letting the carry ripple through the bits. The operands are cut into four slices of four bits each. Every slice forms a carry-make and a carry-pass flag for each bit. It works out its own three inner carries as flat sums of products, and it reports one slice-level make flag and one slice-level pass flag.

A second-level carry unit takes the four slice flag pairs and the external carry-in. With the same flat sum-of-products pattern, it produces the carry that enters each slice and the final carry-out. The slices then finish their sum bits from that incoming carry.

The block is purely combinational and has no clock. It fits wherever a single-cycle add must finish in a short, fixed depth of logic: about seven gate levels from operand to carry-out. The result is 17 bits wide, the sum plus the carry-out.

Top module: `cla16_adder`

## Requirements
- R1: For all operands, the 17-bit value {carry_out, sum_out} equals a_in + b_in + carry_in, read as unsigned numbers.
- R2: With carry_in = 1, the result is one greater than the result for the same operands with carry_in = 0. This includes the wrap from 0xFFFF + 0x0000 + 1 to sum 0x0000 with carry_out 1.
- R3: A carry made in one slice passes through every higher slice whose four bits each have a_in or b_in set. For example, a_in = 0xFFF8 and b_in = 0x0008 with carry_in 0 gives sum 0x0000 and carry_out 1.
- R4: The carry entering slice k+1 (sum bit 4k+4, for k = 0..2) equals the carry that a bitwise add of slice k makes from its own operand bits and its own incoming carry. For example, a_in = b_in = 1 << (4k+3) sets sum bit 4k+4 and clears all other sum bits.
- R5: carry_out is bit 16 of the full sum and equals the carry the top slice (bits 15..12) makes.
- R6: The outputs follow an input change within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits 15..0 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bound checker tests the following on every input change:
- the full 17-bit result against a plain addition;
- each slice's pass and make flags against their bitwise meaning;
- each lookahead carry against a bitwise add of the slice below it;
- the carry-out against the top slice's own carry.

Only the bench scenarios show the following:
- the long pass chains set up by directed operands;
- the carry crossing at each slice boundary in isolation;
- the +1 effect of the carry-in;
- that the outputs settle without any clock.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int GRP_W  = 4;
    localparam int NGRP   = 4;
    localparam int DATA_W = GRP_W * NGRP;

    typedef struct packed {
        logic make;
        logic pass;
    } gp_t;

    // Flat sum-of-products carries for four make/pass pairs.
    // Bit 0 of the result is the seed carry, bit j is the carry after stage j-1.
    function automatic logic [4:0] flat_carries(input logic [3:0] mk,
                                                input logic [3:0] ps,
                                                input logic       seed);
        logic [4:0] c;
        c[0] = seed;
        c[1] = mk[0] | (ps[0] & seed);
        c[2] = mk[1] | (ps[1] & mk[0]) | (ps[1] & ps[0] & seed);
        c[3] = mk[2] | (ps[2] & mk[1]) | (ps[2] & ps[1] & mk[0])
             | (ps[2] & ps[1] & ps[0] & seed);
        c[4] = mk[3] | (ps[3] & mk[2]) | (ps[3] & ps[2] & mk[1])
             | (ps[3] & ps[2] & ps[1] & mk[0])
             | (ps[3] & ps[2] & ps[1] & ps[0] & seed);
        return c;
    endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
    import cla_pkg::*;
#(
    parameter int W = GRP_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output gp_t  [W-1:0] pg
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pg[i].make = a[i] & b[i];
        assign pg[i].pass = a[i] | b[i];
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] a,
    input  logic [GRP_W-1:0] b,
    input  logic             cin,
    output logic [GRP_W-1:0] sum,
    output gp_t              grp
);
    gp_t  [GRP_W-1:0] bit_pg;
    logic [GRP_W-1:0] mk;
    logic [GRP_W-1:0] ps;
    logic [GRP_W:0]   carries;
    logic [GRP_W:0]   gen_only;

    cla_bit_pg #(.W(GRP_W)) u_pg (
        .a  (a),
        .b  (b),
        .pg (bit_pg)
    );

    for (genvar i = 0; i < GRP_W; i++) begin : g_split
        assign mk[i] = bit_pg[i].make;
        assign ps[i] = bit_pg[i].pass;
    end

    assign carries  = flat_carries(mk, ps, cin);
    assign gen_only = flat_carries(mk, ps, 1'b0);

    assign grp.make = gen_only[GRP_W];
    assign grp.pass = &ps;

    for (genvar i = 0; i < GRP_W; i++) begin : g_sum
        assign sum[i] = a[i] ^ b[i] ^ carries[i];
    end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
(
    input  gp_t [NGRP-1:0] grp,
    input  logic           cin,
    output logic [NGRP:0]  grp_cin
);
    logic [NGRP-1:0] gmk;
    logic [NGRP-1:0] gps;

    for (genvar k = 0; k < NGRP; k++) begin : g_unpack
        assign gmk[k] = grp[k].make;
        assign gps[k] = grp[k].pass;
    end

    assign grp_cin = flat_carries(gmk, gps, cin);
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    gp_t  [NGRP-1:0] grp_pg;
    logic [NGRP:0]   grp_cin;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group u_grp (
            .a   (a_in[k*GRP_W +: GRP_W]),
            .b   (b_in[k*GRP_W +: GRP_W]),
            .cin (grp_cin[k]),
            .sum (sum_out[k*GRP_W +: GRP_W]),
            .grp (grp_pg[k])
        );
    end

    cla_carry_unit u_lcu (
        .grp     (grp_pg),
        .cin     (carry_in),
        .grp_cin (grp_cin)
    );

    assign carry_out = grp_cin[NGRP];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk
    import cla_pkg::*;
(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              cin,
    input logic [DATA_W-1:0] sum,
    input logic              cout,
    input gp_t  [NGRP-1:0]   grp_pg,
    input logic [NGRP:0]     grp_cin
);
    logic [DATA_W:0] ref_total;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({a, b, cin, sum, cout})) begin
            AST_SUM_MATCH: assert ({cout, sum} == ref_total); // R1
            AST_COUT_TOP: assert (cout == grp_cin[NGRP]); // R5
        end
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_chk
        logic [GRP_W:0] slice_add;
        logic [GRP_W:0] slice_add0;
        assign slice_add  = {1'b0, a[k*GRP_W +: GRP_W]} + {1'b0, b[k*GRP_W +: GRP_W]}
                          + {{GRP_W{1'b0}}, grp_cin[k]};
        assign slice_add0 = {1'b0, a[k*GRP_W +: GRP_W]} + {1'b0, b[k*GRP_W +: GRP_W]};
        always_comb begin
            if (!$isunknown({a, b, cin, grp_pg, grp_cin})) begin
                AST_GRP_PASS: assert (grp_pg[k].pass == &(a[k*GRP_W +: GRP_W] | b[k*GRP_W +: GRP_W])); // R3
                AST_GRP_MAKE: assert (grp_pg[k].make == slice_add0[GRP_W]); // R3
                AST_LOOKAHEAD_CARRY: assert (grp_cin[k+1] == slice_add[GRP_W]); // R4
            end
        end
    end
endmodule

bind cla16_adder cla16_adder_chk u_chk (
    .a       (a_in),
    .b       (b_in),
    .cin     (carry_in),
    .sum     (sum_out),
    .cout    (carry_out),
    .grp_pg  (grp_pg),
    .grp_cin (grp_cin)
);

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in;
    logic [15:0] b_in;
    logic        carry_in;
    logic [15:0] sum_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla16_adder uut (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y,
                                          input logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    task automatic check17(input string req, input logic [16:0] exp);
        checks++;
        if ({carry_out, sum_out} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, a_in, b_in, carry_in, {carry_out, sum_out}, exp);
        end
    endtask

    // Drive on the falling edge, sample one time unit later.
    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
        @(negedge clk);
        a_in = x; b_in = y; carry_in = c;
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [16:0] r0;
        a_in = 16'h0; b_in = 16'h0; carry_in = 1'b0;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // R1: zero operands
        apply(16'h0000, 16'h0000, 1'b0);
        check17("R1 zero", 17'h0_0000);

        // R6: a change settles with no clock edge between drive and sample
        a_in = 16'h1234; b_in = 16'h0F0F; carry_in = 1'b0;
        #1;
        check17("R6 no clock", model(16'h1234, 16'h0F0F, 1'b0));

        // R2: carry_in adds one, including full wrap
        apply(16'hFFFF, 16'h0000, 1'b1);
        check17("R2 wrap", 17'h1_0000);
        apply(16'h7FFF, 16'h0000, 1'b1);
        check17("R2 plus one", 17'h0_8000);

        // R3: made carry passes through all-pass slices
        apply(16'hFFF8, 16'h0008, 1'b0);
        check17("R3 pass chain", 17'h1_0000);
        apply(16'hF0F0, 16'h0F10, 1'b0);
        check17("R3 mixed pass", model(16'hF0F0, 16'h0F10, 1'b0));
        apply(16'hAAAA, 16'h5555, 1'b1);
        check17("R3 all pass seed", 17'h1_0000);

        // R4: carry crossing each slice boundary alone
        for (int k = 0; k < 3; k++) begin
            apply(16'(1 << (4*k+3)), 16'(1 << (4*k+3)), 1'b0);
            check17("R4 boundary", 17'(1 << (4*k+4)));
        end

        // R5: carry_out from the top slice
        apply(16'h8000, 16'h8000, 1'b0);
        check17("R5 top make", 17'h1_0000);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check17("R5 max", 17'h1_FFFF);
        apply(16'h7000, 16'h8FFF, 1'b0);
        check17("R5 no carry", 17'h0_FFFF);

        // R1/R2: random operands, each with both carry-in values
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            apply(x, y, 1'b0);
            r0 = {carry_out, sum_out};
            check17("R1 random", model(x, y, 1'b0));
            apply(x, y, 1'b1);
            check17("R2 random", r0 + 17'd1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule